// File: doc/BRIEF.md
# Bit-Field Access Unit

This block is the datapath behind bit-field instructions that operate on memory. A field is named by a base byte address, a signed bit offset counted from the most significant bit of that byte, and a width code. From these the unit works out which aligned window of memory holds the whole field, and how many bytes that window has. It then runs one of several operations on the window data: extract, insert, set, clear, change, or find-first-one.

The caller uses the address and size outputs combinationally to fetch the window. It presents the fetched bytes on the window input, right-justified, and pulses the valid strobe. One cycle later the unit returns the registered result, a left-justified copy of the field for condition codes, and, for modifying operations, the window to write back together with a write flag.

Top module: `bitfield_unit`

## Requirements
- R1: A width code of 0 selects a 32-bit field. Codes 1 to 31 select that many bits.
- R2: The window address moves by floor(offset / 8) bytes, and the in-byte bit offset is offset mod 8 taken in the range 0..7. A negative offset therefore borrows one byte downward.
- R3: The span is (in-byte offset + width - 1) / 8. Spans 0, 1, 2-3 and 4 give size_o codes 0, 1, 2 and 3, which mean 1, 2, 4 and 8 bytes. The window bytes sit right-justified in win_i.
- R4: For span 2 at an odd byte address, the window starts one byte lower. For span 4, the window address is rounded down to a multiple of 4 and the field moves 8 bits further into the window for each byte removed.
- R5: op_i = 1 returns the field sign-extended to 32 bits.
- R6: op_i = 0 returns the field zero-extended to 32 bits.
- R7: op_i = 2 writes the low width bits of src_i into the field. It returns src_i shifted left by (32 - width), on both result_o and cc_o.
- R8: op_i = 3, 4 and 5 set, clear and invert the field respectively. Each returns the old field left-justified in 32 bits.
- R9: op_i = 6 returns offset + the number of leading zeros of the left-justified field. When the field is zero it returns offset + width.
- R10: The outputs result_o, cc_o, wdata_o and wr_o are registered one cycle after valid_i. valid_o pulses for one cycle. Without valid_i these outputs hold their values. Reset clears them all.
- R11: In wdata_o, bits outside the field equal win_i. wr_o is 1 only for op_i 2 to 5. For every other operation, wdata_o equals win_i unchanged.
- R12: op_i = 7 is undefined. It returns result 0 and does not write. cc_o carries the old field left-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| addr_i | input | 32 | Base byte address |
| ofs_i | input | 32 | Signed bit offset |
| width_i | input | 5 | Width code, 0 means 32 |
| src_i | input | 32 | Insert source value |
| win_i | input | 64 | Fetched window, right-justified |
| addr_o | output | 32 | Window byte address |
| size_o | output | 2 | Window size code |
| valid_o | output | 1 | Result valid |
| wr_o | output | 1 | Write-back required |
| wdata_o | output | 64 | Window data to write back |
| result_o | output | 32 | Operation result |
| cc_o | output | 32 | Left-justified field for condition codes |

## Verification
The bench sweeps every width code, offsets from -17 to 40, all four low address bits and all eight operation codes, using pseudo-random windows. This exercises every span and both alignment fix-ups.

Offsets just below zero catch an address step that truncates toward zero: that design would fetch the byte above the field. Span-2 fields at odd addresses, and quad windows, catch missing alignment fix-ups, which would request a misaligned window or extract bits shifted by whole bytes. Width code 0 and all-zero fields catch a width treated as 0 and a find-first-one that returns a bogus count. The bench also compares the full write-back window, so any mask that spills past the field edge is reported.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [2:0] {
    BF_EXTU = 3'd0,
    BF_EXTS = 3'd1,
    BF_INS  = 3'd2,
    BF_SET  = 3'd3,
    BF_CLR  = 3'd4,
    BF_CHG  = 3'd5,
    BF_FFO  = 3'd6,
    BF_RSV  = 3'd7
  } bf_op_e;
endpackage

// File: rtl/bfu_locate.sv
module bfu_locate #(
  parameter int W = 32
) (
  input  logic [W-1:0]             addr_i,
  input  logic [W-1:0]             ofs_i,
  input  logic [$clog2(W)-1:0]     width_i,
  output logic [W-1:0]             base_o,
  output logic [1:0]               size_o,
  output logic [$clog2(2*W)-1:0]   pos_o,
  output logic [$clog2(W):0]       len_o
);
  localparam int WIN_W = 2 * W;
  localparam int LEN_W = $clog2(W);
  localparam int POS_W = $clog2(WIN_W);

  logic signed [W-1:0] ofs_s;
  logic [W-1:0]        byte_adr;
  logic [2:0]          bit_ofs;
  logic [LEN_W+1:0]    span_sum;
  logic [LEN_W-2:0]    span;

  assign len_o    = (width_i == '0) ? (LEN_W+1)'(W) : {1'b0, width_i};
  assign ofs_s    = ofs_i;
  assign byte_adr = addr_i + W'(ofs_s >>> 3);  // floor division
  assign bit_ofs  = ofs_i[2:0];
  assign span_sum = (LEN_W+2)'(bit_ofs) + (LEN_W+2)'(len_o) - (LEN_W+2)'(1);
  assign span     = span_sum[LEN_W+1:3];

  always_comb begin
    base_o = byte_adr;
    pos_o  = POS_W'(bit_ofs) + POS_W'(WIN_W - 32);
    size_o = 2'd2;
    case (span)
      (LEN_W-1)'(0): begin
        pos_o  = POS_W'(bit_ofs) + POS_W'(WIN_W - 8);
        size_o = 2'd0;
      end
      (LEN_W-1)'(1): begin
        pos_o  = POS_W'(bit_ofs) + POS_W'(WIN_W - 16);
        size_o = 2'd1;
      end
      (LEN_W-1)'(2): begin
        if (byte_adr[0]) begin
          base_o = byte_adr - W'(1);
          pos_o  = POS_W'(bit_ofs) + POS_W'(WIN_W - 24);
        end
      end
      (LEN_W-1)'(3): ;
      default: begin
        base_o = {byte_adr[W-1:2], 2'b00};
        pos_o  = POS_W'(bit_ofs) + POS_W'({byte_adr[1:0], 3'b000});
        size_o = 2'd3;
      end
    endcase
  end

  // R3
  always_comb begin
    if (!$isunknown({addr_i, ofs_i, width_i}))
      span_fit_chk: assert (32'(pos_o) + 32'(len_o) <= WIN_W);
  end

  // R4
  always_comb begin
    if (!$isunknown({addr_i, ofs_i, width_i}))
      quad_align_chk: assert (size_o != 2'd3 || base_o[1:0] == 2'b00);
  end
endmodule

// File: rtl/bfu_mask.sv
module bfu_mask #(
  parameter int W = 32
) (
  input  logic [$clog2(W):0]       len_i,
  input  logic [$clog2(2*W)-1:0]   pos_i,
  output logic [2*W-1:0]           mask_o
);
  localparam int WIN_W = 2 * W;

  assign mask_o = ~({WIN_W{1'b1}} >> len_i) >> pos_i;

  // R1
  always_comb begin
    if (!$isunknown({len_i, pos_i}))
      mask_width_chk: assert ($countones(mask_o) == 32'(len_i));
  end
endmodule

// File: rtl/bfu_alu.sv
module bfu_alu
  import bfu_pkg::*;
#(
  parameter int W = 32
) (
  input  bf_op_e                   op_i,
  input  logic [2*W-1:0]           win_i,
  input  logic [2*W-1:0]           mask_i,
  input  logic [$clog2(2*W)-1:0]   pos_i,
  input  logic [$clog2(W):0]       len_i,
  input  logic [W-1:0]             src_i,
  input  logic [W-1:0]             ofs_i,
  output logic [W-1:0]             result_o,
  output logic [W-1:0]             cc_o,
  output logic [2*W-1:0]           wdata_o,
  output logic                     wr_o
);
  localparam int WIN_W = 2 * W;
  localparam int LEN_W = $clog2(W);

  logic [WIN_W-1:0]  old_w, ins_w;
  logic [W-1:0]      old_lj, zext, ins_lj, ffo;
  logic signed [W-1:0] old_s;
  logic [LEN_W:0]    shamt, lead;

  assign old_w  = (win_i & mask_i) << pos_i;
  assign old_lj = old_w[WIN_W-1:W];
  assign shamt  = (LEN_W+1)'(W) - len_i;
  assign zext   = old_lj >> shamt;
  assign old_s  = old_lj;
  assign ins_lj = src_i << shamt;
  assign ins_w  = {ins_lj, {W{1'b0}}} >> pos_i;

  always_comb begin
    lead = len_i;
    for (int i = 0; i < W; i++)
      if (old_lj[i]) lead = (LEN_W+1)'(W - 1 - i);
  end
  assign ffo = ofs_i + W'(lead);

  always_comb begin
    result_o = '0;
    cc_o     = old_lj;
    wdata_o  = win_i;
    wr_o     = 1'b0;
    unique case (op_i)
      BF_EXTU: result_o = zext;
      BF_EXTS: result_o = $unsigned(old_s >>> shamt);
      BF_INS: begin
        result_o = ins_lj;
        cc_o     = ins_lj;
        wdata_o  = (win_i & ~mask_i) | (ins_w & mask_i);
        wr_o     = 1'b1;
      end
      BF_SET: begin result_o = old_lj; wdata_o = win_i | mask_i;  wr_o = 1'b1; end
      BF_CLR: begin result_o = old_lj; wdata_o = win_i & ~mask_i; wr_o = 1'b1; end
      BF_CHG: begin result_o = old_lj; wdata_o = win_i ^ mask_i;  wr_o = 1'b1; end
      BF_FFO: result_o = ffo;
      default: ;
    endcase
  end

  // R11
  always_comb begin
    if (!$isunknown({win_i, mask_i, op_i, src_i}))
      keep_outside_chk: assert (((wdata_o ^ win_i) & ~mask_i) == '0);
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [2:0]  op_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] ofs_i,
  input  logic [4:0]  width_i,
  input  logic [31:0] src_i,
  input  logic [63:0] win_i,
  output logic [31:0] addr_o,
  output logic [1:0]  size_o,
  output logic        valid_o,
  output logic        wr_o,
  output logic [63:0] wdata_o,
  output logic [31:0] result_o,
  output logic [31:0] cc_o
);
  localparam int W     = 32;
  localparam int WIN_W = 2 * W;
  localparam int LEN_W = $clog2(W);
  localparam int POS_W = $clog2(WIN_W);

  logic [POS_W-1:0] pos;
  logic [LEN_W:0]   len;
  logic [WIN_W-1:0] mask, wdata_d;
  logic [W-1:0]     result_d, cc_d;
  logic             wr_d;

  bfu_locate #(.W(W)) u_locate (
    .addr_i(addr_i), .ofs_i(ofs_i), .width_i(width_i),
    .base_o(addr_o), .size_o(size_o), .pos_o(pos), .len_o(len)
  );

  bfu_mask #(.W(W)) u_mask (
    .len_i(len), .pos_i(pos), .mask_o(mask)
  );

  bfu_alu #(.W(W)) u_alu (
    .op_i(bf_op_e'(op_i)), .win_i(win_i), .mask_i(mask), .pos_i(pos),
    .len_i(len), .src_i(src_i), .ofs_i(ofs_i),
    .result_o(result_d), .cc_o(cc_d), .wdata_o(wdata_d), .wr_o(wr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_o     <= 1'b0;
      wdata_o  <= '0;
      result_o <= '0;
      cc_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        wr_o     <= wr_d;
        wdata_o  <= wdata_d;
        result_o <= result_d;
        cc_o     <= cc_d;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(wdata_o) && $stable(cc_o)));

  // R11
  wr_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i < 3'd2 || op_i > 3'd5)) |=> !wr_o);
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] addr_i = '0, ofs_i = '0, src_i = '0;
  logic [4:0]  width_i = '0;
  logic [63:0] win_i = '0;
  logic [31:0] addr_o, result_o, cc_o;
  logic [1:0]  size_o;
  logic        valid_o, wr_o;
  logic [63:0] wdata_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .addr_i(addr_i), .ofs_i(ofs_i), .width_i(width_i), .src_i(src_i),
    .win_i(win_i), .addr_o(addr_o), .size_o(size_o), .valid_o(valid_o),
    .wr_o(wr_o), .wdata_o(wdata_o), .result_o(result_o), .cc_o(cc_o)
  );

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic [31:0] adr, input int ofs, input int w);
    int len, q, r, span, pos, cnt;
    logic [31:0] a, fv, sv, lj, ins_lj, exp_res, exp_cc;
    logic [1:0]  sz;
    logic [63:0] nw, fmask;
    string tg;
    bit found;
    len = (w == 0) ? 32 : w;
    q = ofs / 8; r = ofs % 8;
    if (r < 0) begin r += 8; q -= 1; end
    a = adr + q;
    span = (r + len - 1) / 8;
    tg = (ofs < 0) ? "R2" : "R3";
    case (span)
      0: begin pos = r + 56; sz = 2'd0; end
      1: begin pos = r + 48; sz = 2'd1; end
      2: begin
        sz = 2'd2;
        if (a[0]) begin a = a - 1; pos = r + 40; tg = "R4"; end
        else pos = r + 32;
      end
      3: begin pos = r + 32; sz = 2'd2; end
      default: begin pos = r + 8 * int'(a[1:0]); a = {a[31:2], 2'b00}; sz = 2'd3; tg = "R4"; end
    endcase
    rng = next_rng(rng); win_i = rng;
    rng = next_rng(rng); src_i = rng[40:9];
    op_i = 3'(op); addr_i = adr; ofs_i = ofs; width_i = 5'(w); valid_i = 1'b1;
    fv = '0; fmask = '0; cnt = len; found = 0;
    for (int i = 0; i < len; i++) begin
      fv = {fv[30:0], win_i[63-pos-i]};
      fmask[63-pos-i] = 1'b1;
      if (!found && win_i[63-pos-i]) begin cnt = i; found = 1; end
    end
    sv = fv;
    if (fv[len-1]) for (int i = len; i < 32; i++) sv[i] = 1'b1;
    lj = fv << (32 - len);
    ins_lj = src_i << (32 - len);
    nw = win_i;
    for (int i = 0; i < len; i++) begin
      case (op)
        2: nw[63-pos-i] = src_i[len-1-i];
        3: nw[63-pos-i] = 1'b1;
        4: nw[63-pos-i] = 1'b0;
        5: nw[63-pos-i] = ~win_i[63-pos-i];
        default: ;
      endcase
    end
    case (op)
      0: exp_res = fv;
      1: exp_res = sv;
      2: exp_res = ins_lj;
      3, 4, 5: exp_res = lj;
      6: exp_res = ofs + cnt;
      default: exp_res = '0;
    endcase
    exp_cc = (op == 2) ? ins_lj : lj;
    #2;
    chk(addr_o == a && size_o == sz, tg, "window addr/size",
        {addr_o, 30'd0, size_o}, {a, 30'd0, sz});
    @(negedge clk);
    case (op)
      0: tg = (w == 0) ? "R1" : "R6";
      1: tg = "R5";
      2: tg = "R7";
      3, 4, 5: tg = "R8";
      6: tg = "R9";
      default: tg = "R12";
    endcase
    chk(valid_o === 1'b1, "R10", "valid pulse", 64'(valid_o), 64'd1);
    chk(result_o === exp_res, tg, "result", 64'(result_o), 64'(exp_res));
    chk(cc_o === exp_cc, tg, "cc field", 64'(cc_o), 64'(exp_cc));
    chk(wr_o === (op >= 2 && op <= 5), "R11", "write flag", 64'(wr_o), 64'(op >= 2 && op <= 5));
    chk(wdata_o === nw, (op >= 2 && op <= 5) ? tg : "R11", "write-back window", wdata_o, nw);
    chk(((wdata_o ^ win_i) & ~fmask) == 64'd0, "R11", "bits outside field", wdata_o, win_i);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(valid_o === 1'b0 && wr_o === 1'b0 && result_o === '0 && wdata_o === '0 && cc_o === '0,
        "R10", "reset state", {31'd0, valid_o, result_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int lo = 0; lo < 4; lo++)
      for (int ofs = -17; ofs <= 40; ofs++)
        for (int w = 0; w < 32; w++)
          for (int op = 0; op < 8; op++)
            run_op(op, 32'h0000_2460 + 32'(lo), ofs, w);
    // R1 and R9: all-zero 32-bit field, find-first-one returns offset + 32
    op_i = 3'd6; addr_i = 32'h100; ofs_i = 32'd4; width_i = 5'd0; win_i = '0; valid_i = 1'b1;
    @(negedge clk);
    chk(result_o === 32'd36, "R9", "ffo on zero field", 64'(result_o), 64'd36);
    // R10 hold without strobe
    held = result_o;
    valid_i = 1'b0; op_i = 3'd3; win_i = 64'h0123_4567_89AB_CDEF; ofs_i = 32'd3;
    @(negedge clk);
    chk(valid_o === 1'b0 && result_o === held && wr_o === 1'b0, "R10", "hold when idle",
        64'(result_o), 64'(held));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule